// File: doc/BRIEF.md
# SENT frame diagnostic checker

This block judges the timing and content of decoded SENT frames on one receive channel. Upstream logic measures pulses and decodes nibbles. It hands over each result with its own one-cycle strobe: the length of every calibration pulse in measurement-clock counts, the number of falling edges counted between two calibration pulses, each decoded nibble value as a signed number, a CRC-match flag, and the result of the pause-pulse diagnostic. The checker turns these into sticky error flags, one combined interrupt line and a reject signal. The frame assembler uses the reject signal to drop frame content.

When a check fails, the channel enters a rejecting state. It stays there until a calibration pulse arrives that is both in range and consistent with the one before it. While the channel is rejecting, newly failing checks do not set their flags, with one exception: the edge-count check always reports. The pause-pulse diagnostic only sets its own flag and never starts rejection. Software clears flags by writing ones to them, and reads the flags to learn which error raised the interrupt.

Calibration lengths are counted in a clock that runs `TICK_CNT` counts per protocol tick. With the defaults, one tick is 8 counts and a nominal 56-tick pulse is 448 counts.

Top module: `sent_diag_checker`

## Requirements
- R1: A calibration pulse shorter than 336 counts or longer than 560 counts sets flag bit 0 and starts rejection. Lengths 336 and 560 themselves are accepted. These limits are 42 and 70 ticks of 8 counts.
- R2: An edge count that differs from `cfg_edges` sets flag bit 1 and starts rejection. This flag is set even while the channel is rejecting.
- R3: A nibble value (6-bit two's complement) below 0 or above 15 sets flag bit 2 and starts rejection.
- R4: An in-range calibration pulse whose absolute difference from the previous in-range pulse, multiplied by 64, exceeds the previous length sets flag bit 3 and starts rejection. Every in-range pulse becomes the new previous length. Out-of-range pulses do not.
- R5: The first in-range calibration pulse after reset is not compared with any earlier pulse.
- R6: A strobe with the CRC-match flag low sets flag bit 4 and starts rejection.
- R7: `reject` rises one cycle after a failing check. It falls one cycle after a calibration pulse that is in range, passes R4, and arrives in a cycle with no other failing check.
- R8: While `reject` is high, failing checks other than the edge-count check leave their flags unchanged.
- R9: A failing pause diagnostic sets flag bit 5 only when `reject` is low, and it never changes `reject`.
- R10: Flags are sticky. A cycle with `clr_wr` high clears each flag whose `clr_bits` bit is 1. A flag that is being set in that same cycle stays set.
- R11: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R12: After reset all flags, `reject` and `irq` are low. Flags and `reject` update on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_valid | input | 1 | Calibration length strobe |
| cal_len | input | 12 | Calibration pulse length in counts |
| edge_valid | input | 1 | Edge count strobe |
| edge_count | input | 5 | Falling edges between calibration pulses |
| cfg_edges | input | 5 | Expected falling edges per message |
| nib_valid | input | 1 | Nibble strobe |
| nib_value | input | 6 | Nibble value, two's complement |
| crc_valid | input | 1 | CRC result strobe |
| crc_ok | input | 1 | CRC matched |
| pause_valid | input | 1 | Pause diagnostic strobe |
| pause_ok | input | 1 | Pause diagnostic passed |
| clr_wr | input | 1 | Flag clear write |
| clr_bits | input | 6 | Flags to clear, one per bit |
| irq_en | input | 1 | Interrupt enable |
| status | output | 6 | Sticky error flags |
| reject | output | 1 | Frame reject |
| irq | output | 1 | Combined error interrupt |

## Verification
Every flag and `reject` is due on the first rising edge after its strobe. `irq` follows the registered flags and the `irq_en` input combinationally, so it is due in the same cycle as the flags, and it follows a change of `irq_en` with no delay. The bench drives each stimulus 1 ns after a rising edge, holds it across exactly one edge, and samples 1 ns after that edge, so every check reads the state one register stage after its stimulus. The successive-pulse state depends on history. For that reason the vector walk orders its pulses so that the stored previous length is known at each step, and the boundary cases start from a fresh reset.

// File: rtl/sent_diag_pkg.sv
package sent_diag_pkg;
  localparam int NUM_ERR   = 6;
  localparam int ERR_CAL   = 0;
  localparam int ERR_EDGE  = 1;
  localparam int ERR_NIB   = 2;
  localparam int ERR_SUCC  = 3;
  localparam int ERR_CRC   = 4;
  localparam int ERR_PAUSE = 5;

  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/sent_cal_check.sv
module sent_cal_check #(
  parameter int CAL_W      = 12,
  parameter int TICK_CNT   = 8,
  parameter int NOM_TICKS  = 56,
  parameter int TOL_DIV    = 4,
  parameter int SUCC_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_valid,
  input  logic [CAL_W-1:0] cal_len,
  output logic             range_err,
  output logic             succ_err,
  output logic             cal_good
);
  localparam int NOM_CNT = NOM_TICKS * TICK_CNT;
  localparam int TOL_CNT = NOM_CNT / TOL_DIV;
  localparam logic [CAL_W-1:0] LEN_LO = CAL_W'(NOM_CNT - TOL_CNT);
  localparam logic [CAL_W-1:0] LEN_HI = CAL_W'(NOM_CNT + TOL_CNT);
  localparam int PROD_W = CAL_W + SUCC_SHIFT;

  logic [CAL_W-1:0]  prev_q, prev_d;
  logic              have_q, have_d;
  logic              in_range;
  logic              upd_en;
  logic [CAL_W-1:0]  diff;
  logic [PROD_W-1:0] diff_scaled;
  logic [PROD_W-1:0] prev_ext;
  logic              too_far;

  always_comb begin
    in_range    = (cal_len >= LEN_LO) && (cal_len <= LEN_HI);
    diff        = (cal_len >= prev_q) ? (cal_len - prev_q) : (prev_q - cal_len);
    diff_scaled = {diff, {SUCC_SHIFT{1'b0}}};
    prev_ext    = {{SUCC_SHIFT{1'b0}}, prev_q};
    too_far     = diff_scaled > prev_ext;
    range_err   = cal_valid && !in_range;
    succ_err    = cal_valid && in_range && have_q && too_far;
    cal_good    = cal_valid && in_range && !(have_q && too_far);
    upd_en      = cal_valid && in_range;
  end

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (upd_en) begin
      prev_d = cal_len;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (upd_en) begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end
endmodule

// File: rtl/sent_content_check.sv
module sent_content_check #(
  parameter int EDGE_W  = 5,
  parameter int NIB_W   = 6,
  parameter int NIB_MAX = 15
) (
  input  logic              edge_valid,
  input  logic [EDGE_W-1:0] edge_count,
  input  logic [EDGE_W-1:0] cfg_edges,
  input  logic              nib_valid,
  input  logic [NIB_W-1:0]  nib_value,
  input  logic              crc_valid,
  input  logic              crc_ok,
  input  logic              pause_valid,
  input  logic              pause_ok,
  output logic              edge_err,
  output logic              nib_err,
  output logic              crc_err,
  output logic              pause_err
);
  localparam logic [NIB_W-2:0] NIB_HI = (NIB_W-1)'(NIB_MAX);

  logic nib_neg;
  logic nib_over;

  always_comb begin
    nib_neg   = nib_value[NIB_W-1];
    nib_over  = !nib_neg && (nib_value[NIB_W-2:0] > NIB_HI);
    edge_err  = edge_valid && (edge_count != cfg_edges);
    nib_err   = nib_valid && (nib_neg || nib_over);
    crc_err   = crc_valid && !crc_ok;
    pause_err = pause_valid && !pause_ok;
  end
endmodule

// File: rtl/sent_status_regs.sv
module sent_status_regs
  import sent_diag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t raw_err,
  input  logic     cal_good,
  input  logic     clr_wr,
  input  err_vec_t clr_bits,
  input  logic     irq_en,
  output err_vec_t status,
  output logic     reject,
  output logic     irq
);
  err_vec_t st_q, st_d, set_v;
  logic     rej_q, rej_d;
  logic     starts_reject;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    localparam bit UNMASKED = (i == ERR_EDGE);
    always_comb begin
      set_v[i] = raw_err[i] && (UNMASKED || !rej_q);
      st_d[i]  = set_v[i] || (st_q[i] && !(clr_wr && clr_bits[i]));
    end
  end

  always_comb begin
    starts_reject = |(raw_err & ~(err_vec_t'(1) << ERR_PAUSE));
    rej_d         = starts_reject || (rej_q && !cal_good);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      rej_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rej_q <= rej_d;
    end
  end

  assign status = st_q;
  assign reject = rej_q;
  assign irq    = irq_en && (|st_q);
endmodule

// File: rtl/sent_diag_checker.sv
module sent_diag_checker
  import sent_diag_pkg::*;
#(
  parameter int CAL_W     = 12,
  parameter int TICK_CNT  = 8,
  parameter int NOM_TICKS = 56,
  parameter int EDGE_W    = 5,
  parameter int NIB_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_valid,
  input  logic [CAL_W-1:0]  cal_len,
  input  logic              edge_valid,
  input  logic [EDGE_W-1:0] edge_count,
  input  logic [EDGE_W-1:0] cfg_edges,
  input  logic              nib_valid,
  input  logic [NIB_W-1:0]  nib_value,
  input  logic              crc_valid,
  input  logic              crc_ok,
  input  logic              pause_valid,
  input  logic              pause_ok,
  input  logic              clr_wr,
  input  logic [5:0]        clr_bits,
  input  logic              irq_en,
  output logic [5:0]        status,
  output logic              reject,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  err_vec_t   raw_err;
  logic       range_err, succ_err, cal_good;
  logic       edge_err, nib_err, crc_err, pause_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sent_cal_check #(
    .CAL_W(CAL_W), .TICK_CNT(TICK_CNT), .NOM_TICKS(NOM_TICKS),
    .TOL_DIV(4), .SUCC_SHIFT(6)
  ) u_cal (
    .clk(clk), .rst_n(rst_sync_n), .cal_valid(cal_valid), .cal_len(cal_len),
    .range_err(range_err), .succ_err(succ_err), .cal_good(cal_good)
  );

  sent_content_check #(
    .EDGE_W(EDGE_W), .NIB_W(NIB_W), .NIB_MAX(15)
  ) u_content (
    .edge_valid(edge_valid), .edge_count(edge_count), .cfg_edges(cfg_edges),
    .nib_valid(nib_valid), .nib_value(nib_value),
    .crc_valid(crc_valid), .crc_ok(crc_ok),
    .pause_valid(pause_valid), .pause_ok(pause_ok),
    .edge_err(edge_err), .nib_err(nib_err), .crc_err(crc_err), .pause_err(pause_err)
  );

  always_comb begin
    raw_err            = '0;
    raw_err[ERR_CAL]   = range_err;
    raw_err[ERR_EDGE]  = edge_err;
    raw_err[ERR_NIB]   = nib_err;
    raw_err[ERR_SUCC]  = succ_err;
    raw_err[ERR_CRC]   = crc_err;
    raw_err[ERR_PAUSE] = pause_err;
  end

  sent_status_regs u_status (
    .clk(clk), .rst_n(rst_sync_n), .raw_err(raw_err), .cal_good(cal_good),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .irq_en(irq_en),
    .status(status), .reject(reject), .irq(irq)
  );
endmodule

// File: rtl/sent_diag_checker_sva.sv
module sent_diag_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cal_valid,
  input logic [11:0] cal_len,
  input logic        edge_valid,
  input logic [4:0]  edge_count,
  input logic [4:0]  cfg_edges,
  input logic        nib_valid,
  input logic [5:0]  nib_value,
  input logic        crc_valid,
  input logic        crc_ok,
  input logic        pause_valid,
  input logic        pause_ok,
  input logic        clr_wr,
  input logic        irq_en,
  input logic [5:0]  status,
  input logic        reject,
  input logic        irq
);
  logic other_strobe;
  assign other_strobe = cal_valid || edge_valid || nib_valid || crc_valid;

  AST_CAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid && !reject && ((cal_len < 12'd336) || (cal_len > 12'd560)))
      |=> (status[0] && reject)) else $error("cal range"); // R1

  AST_EDGE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid && (edge_count != cfg_edges)) |=> (status[1] && reject))
    else $error("edge count"); // R2

  AST_NIB_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && (nib_value[5] || (nib_value[4:0] > 5'd15))) |=> reject)
    else $error("nibble"); // R3

  AST_CRC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_valid && !crc_ok) |=> reject) else $error("crc"); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ((status & ~$past(status) & 6'b111101) == 6'b0))
    else $error("masking"); // R8

  AST_PAUSE_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!reject && pause_valid && !other_strobe) |=> !reject)
    else $error("pause"); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr) |=> ((~status & $past(status)) == 6'b0))
    else $error("sticky"); // R10

  always_comb begin
    if (rst_n && !irq_en) AST_IRQ_GATED: assert (!irq) else $error("irq gate"); // R11
    if (rst_n && status == 6'b0) AST_IRQ_IDLE: assert (!irq) else $error("irq idle"); // R11
  end
endmodule

bind sent_diag_checker sent_diag_checker_sva u_sva (
  .clk(clk), .rst_n(rst_sync_n), .cal_valid(cal_valid), .cal_len(cal_len),
  .edge_valid(edge_valid), .edge_count(edge_count), .cfg_edges(cfg_edges),
  .nib_valid(nib_valid), .nib_value(nib_value), .crc_valid(crc_valid),
  .crc_ok(crc_ok), .pause_valid(pause_valid), .pause_ok(pause_ok),
  .clr_wr(clr_wr), .irq_en(irq_en), .status(status), .reject(reject), .irq(irq)
);

// File: tb/sent_diag_checker_bench.sv
module sent_diag_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cal_valid, edge_valid, nib_valid, crc_valid, crc_ok;
  logic        pause_valid, pause_ok, clr_wr, irq_en;
  logic [11:0] cal_len;
  logic [4:0]  edge_count, cfg_edges;
  logic [5:0]  nib_value, clr_bits;
  logic [5:0]  status;
  logic        reject, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sent_diag_checker u_sent_diag_checker (
    .clk(clk), .rst_n(rst_n), .cal_valid(cal_valid), .cal_len(cal_len),
    .edge_valid(edge_valid), .edge_count(edge_count), .cfg_edges(cfg_edges),
    .nib_valid(nib_valid), .nib_value(nib_value), .crc_valid(crc_valid),
    .crc_ok(crc_ok), .pause_valid(pause_valid), .pause_ok(pause_ok),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .irq_en(irq_en),
    .status(status), .reject(reject), .irq(irq)
  );

  typedef struct packed {
    logic        cv;
    logic [11:0] cl;
    logic        ev;
    logic [4:0]  ec;
    logic        nv;
    logic [5:0]  nb;
    logic        kv;
    logic        kok;
    logic        pv;
    logic        pok;
    logic [5:0]  clr;
    logic [5:0]  est;
    logic        erej;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'd448, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 8'd5},  // R5 first
    '{1'b0, 12'd0,   1'b1, 5'd8, 1'b1, 6'd5,  1'b1, 1'b1, 1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 8'd2},  // R2 R3 R6 good
    '{1'b1, 12'd455, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 8'd4},  // R4 d=7 ok
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b1, 6'd16, 1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h04, 1'b1, 8'd3},  // R3 over
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 6'h04, 1'b1, 8'd8},  // R8 crc masked
    '{1'b0, 12'd0,   1'b1, 5'd7, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h06, 1'b1, 8'd2},  // R2 unmasked
    '{1'b1, 12'd455, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h06, 1'b0, 8'd7},  // R7 release
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h06, 6'h00, 1'b0, 8'd10}, // R10 clear
    '{1'b1, 12'd447, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h08, 1'b1, 8'd4},  // R4 d=8 err
    '{1'b1, 12'd300, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h08, 1'b1, 8'd8},  // R8 cal masked
    '{1'b1, 12'd447, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h08, 1'b0, 8'd7},  // R7 release
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 6'h00, 6'h28, 1'b0, 8'd9},  // R9 no reject
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b1, 6'h3F, 1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h2C, 1'b1, 8'd3},  // R3 negative
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h3F, 6'h00, 1'b1, 8'd10}, // R10 clear all
    '{1'b1, 12'd600, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h00, 1'b1, 8'd8},  // R8 masked
    '{1'b1, 12'd447, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 8'd4},  // R4 prev kept
    '{1'b1, 12'd335, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h01, 1'b1, 8'd1},  // R1 low edge
    '{1'b1, 12'd447, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h01, 1'b0, 8'd7},  // R7 release
    '{1'b0, 12'd0,   1'b0, 5'd0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 1'b1, 6'h01, 6'h10, 1'b1, 8'd6},  // R6 R10
    '{1'b1, 12'd336, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h10, 1'b1, 8'd4},  // R4 stored
    '{1'b1, 12'd336, 1'b0, 5'd0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 6'h00, 6'h10, 1'b0, 8'd1}   // R1 R7 336 ok
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cal_valid = 1'b0; cal_len = '0; edge_valid = 1'b0; edge_count = '0;
    nib_valid = 1'b0; nib_value = '0; crc_valid = 1'b0; crc_ok = 1'b1;
    pause_valid = 1'b0; pause_ok = 1'b1; clr_wr = 1'b0; clr_bits = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic apply(input vec_t v);
    cal_valid = v.cv; cal_len = v.cl; edge_valid = v.ev; edge_count = v.ec;
    nib_valid = v.nv; nib_value = v.nb; crc_valid = v.kv; crc_ok = v.kok;
    pause_valid = v.pv; pause_ok = v.pok; clr_wr = (v.clr != 0); clr_bits = v.clr;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic cal_pulse(input logic [11:0] len);
    cal_valid = 1'b1; cal_len = len;
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    cfg_edges = 5'd8;
    irq_en    = 1'b1;
    do_reset();
    chk("R12 reset status", status, 0);
    chk("R12 reset reject", reject, 0);
    chk("R12 reset irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk($sformatf("R%0d vec%0d status", VECS[i].req, i), status, VECS[i].est);
      chk($sformatf("R%0d vec%0d reject", VECS[i].req, i), reject, VECS[i].erej);
      chk($sformatf("R11 vec%0d irq", i), irq, (VECS[i].est != 0));
    end

    irq_en = 1'b0; #1;
    chk("R11 irq disabled", irq, 0);
    irq_en = 1'b1; #1;
    chk("R11 irq enabled", irq, 1);

    do_reset();
    cal_pulse(12'd560);
    chk("R5 first pulse 560 status", status, 0);
    chk("R1 upper bound reject", reject, 0);
    cal_pulse(12'd561);
    chk("R1 561 status", status, 6'h01);
    chk("R1 561 reject", reject, 1);

    do_reset();
    cal_pulse(12'd336);
    cal_pulse(12'd341);
    chk("R4 d=5 status", status, 0);
    chk("R4 d=5 reject", reject, 0);
    cal_pulse(12'd347);
    chk("R4 d=6 status", status, 6'h08);
    chk("R4 d=6 reject", reject, 1);

    pause_valid = 1'b1; pause_ok = 1'b0;
    @(posedge clk); #1; idle();
    chk("R9 pause masked status", status, 6'h08);
    chk("R9 pause masked reject", reject, 1);

    edge_valid = 1'b1; edge_count = 5'd3; clr_wr = 1'b1; clr_bits = 6'h0A;
    @(posedge clk); #1; idle();
    chk("R10 set beats clear", status, 6'h02);
    chk("R2 reject held", reject, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule